// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block times a single programmed-I/O access to a drive port. A requester offers a cycle with `req_valid`, and marks it as a data-port or a command/control-port access and as a read or a write. When the block accepts the cycle, it takes the matching 8-bit timing byte and decodes three phase lengths from it. It then holds the address-valid qualifier through a setup phase. Next it asserts the read or the write strobe for the active phase. After that it drops the strobe for a hold phase. Last it raises `done` for one clock and returns to idle.

Two timing bytes are supplied from configuration: one for data-port cycles and one for command/control cycles. Both drives on the channel share the same pair. Typical values are 0xF5 for the slowest data mode, 0x00 for the fastest data mode and 0xDE for command/control cycles. A drive can hold off the end of the active phase with IORDY, but only while the IORDY-enable input is set.

Top module: `pio_strobe_gen`

## Requirements
- R1: While reset is asserted and on the first clock after it, `req_ready` is 1 and `addr_valid`, `rd_strobe`, `wr_strobe` and `done` are 0.
- R2: A cycle is accepted on a rising edge where `req_valid` and `req_ready` are both 1. From the next clock, `addr_valid` is 1 with no strobe for a setup time set by timing byte bits 7:6: 00/01/10/11 give 1/2/3/4 clocks.
- R3: The active phase follows setup. Its length is set by bits 2:0: codes 0 to 7 give 2, 3, 4, 5, 6, 8, 12, 16 clocks of strobe, with `addr_valid` still 1.
- R4: The hold phase follows the strobe. Its length is set by bits 5:3: codes 0 to 7 give 1, 2, 3, 4, 5, 6, 8, 12 clocks with `addr_valid` 1 and no strobe.
- R5: With `req_cmd`=0 the cycle uses `data_timing`. With `req_cmd`=1 it uses `ctrl_timing`.
- R6: `req_write`=1 selects `wr_strobe` and `req_write`=0 selects `rd_strobe`. The two strobes are never 1 together.
- R7: `done` is 1 for exactly one clock, the clock after the last hold clock. On that clock `addr_valid` is 0, and `req_ready` returns to 1 on the next clock.
- R8: `req_ready` is 0 from the clock after acceptance through the `done` clock. A `req_valid` seen while `req_ready` is 0 starts nothing.
- R9: If `iordy_en`=1 and `iordy`=0 at the edge ending the last active clock, the active phase goes on until an edge samples `iordy`=1. With `iordy_en`=0, `iordy` has no effect, and IORDY low before the last active clock has no effect either.
- R10: The timing byte is captured at acceptance. Changing either timing input during a cycle does not change that cycle's phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cycle request |
| req_cmd | input | 1 | 1 = command/control port, 0 = data port |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Block idle, request can be taken |
| data_timing | input | 8 | Timing byte for data-port cycles |
| ctrl_timing | input | 8 | Timing byte for command/control cycles |
| iordy_en | input | 1 | Honour IORDY |
| iordy | input | 1 | Drive ready, low stretches active phase |
| addr_valid | output | 1 | High through setup, active and hold |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The hardest case to reach is IORDY low at exactly the final active clock. IORDY dropping earlier in the active phase must not count. To cover both, the stimulus drops IORDY when it issues the request and raises it a fixed number of clocks after acceptance. It uses windows both shorter and longer than setup plus active, together with a 16-clock active code that lets a low pulse sit entirely inside the phase. A second hard case is a timing byte that changes under a running cycle. The bench rewrites the byte on the clock after acceptance, and in a separate test holds `req_valid` high through whole cycles so that requests arrive while the block is busy.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;
    localparam int unsigned TB_W  = 8;
    localparam int unsigned CNT_W = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_HOLD,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] hold;
    } phase_len_t;
endpackage

// File: rtl/pio_timing_decode.sv
module pio_timing_decode
    import pio_timing_pkg::*;
(
    input  logic [TB_W-1:0] tbyte,
    output phase_len_t      len
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    always_comb begin
        len.setup = CNT_W'(tbyte[7:6]) + ONE;

        unique case (tbyte[5:3])
            3'd6:    len.hold = CNT_W'(8);
            3'd7:    len.hold = CNT_W'(12);
            default: len.hold = CNT_W'(tbyte[5:3]) + ONE;
        endcase

        unique case (tbyte[2:0])
            3'd5:    len.active = CNT_W'(8);
            3'd6:    len.active = CNT_W'(12);
            3'd7:    len.active = CNT_W'(16);
            default: len.active = CNT_W'(tbyte[2:0]) + TWO;
        endcase
    end
endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
    import pio_timing_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [TB_W-1:0] start_byte,
    input  logic            start_write,
    input  logic            iordy_en,
    input  logic            iordy,
    output logic            ready,
    output logic            addr_valid,
    output logic            rd_strobe,
    output logic            wr_strobe,
    output logic            done
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [TB_W-1:0]  tbyte;
        logic             write;
        logic             ready;
        logic             av;
        logic             rd;
        logic             wr;
        logic             done;
    } st_t;

    st_t        st_d, st_q;
    phase_len_t len;
    logic       last_setup, last_active, last_hold, stretch;

    pio_timing_decode u_dec (
        .tbyte (st_q.tbyte),
        .len   (len)
    );

    assign last_setup  = (st_q.cnt == len.setup  - CNT_W'(1));
    assign last_active = (st_q.cnt == len.active - CNT_W'(1));
    assign last_hold   = (st_q.cnt == len.hold   - CNT_W'(1));
    assign stretch     = iordy_en && !iordy;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph    = PH_SETUP;
                    st_d.cnt   = '0;
                    st_d.tbyte = start_byte;
                    st_d.write = start_write;
                end
            end
            PH_SETUP: begin
                if (last_setup) begin
                    st_d.ph  = PH_ACTIVE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_ACTIVE: begin
                if (last_active) begin
                    if (!stretch) begin
                        st_d.ph  = PH_HOLD;
                        st_d.cnt = '0;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (last_hold) begin
                    st_d.ph  = PH_DONE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_DONE: begin
                st_d.ph = PH_IDLE;
            end
            default: begin
                st_d.ph = PH_IDLE;
            end
        endcase

        st_d.ready = (st_d.ph == PH_IDLE);
        st_d.av    = (st_d.ph == PH_SETUP) || (st_d.ph == PH_ACTIVE) || (st_d.ph == PH_HOLD);
        st_d.rd    = (st_d.ph == PH_ACTIVE) && !st_d.write;
        st_d.wr    = (st_d.ph == PH_ACTIVE) &&  st_d.write;
        st_d.done  = (st_d.ph == PH_DONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ph    <= PH_IDLE;
            st_q.ready <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready      = st_q.ready;
    assign addr_valid = st_q.av;
    assign rd_strobe  = st_q.rd;
    assign wr_strobe  = st_q.wr;
    assign done       = st_q.done;

    // R9
    iordy_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_ACTIVE && last_active && iordy_en && !iordy) |=> (st_q.ph == PH_ACTIVE));

    // R9
    iordy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_ACTIVE && last_active && (!iordy_en || iordy)) |=> (st_q.ph == PH_HOLD));

    // R10
    byte_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != PH_IDLE && $past(st_q.ph) != PH_IDLE) |-> $stable(st_q.tbyte));
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
    import pio_timing_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_cmd,
    input  logic            req_write,
    output logic            req_ready,
    input  logic [TB_W-1:0] data_timing,
    input  logic [TB_W-1:0] ctrl_timing,
    input  logic            iordy_en,
    input  logic            iordy,
    output logic            addr_valid,
    output logic            rd_strobe,
    output logic            wr_strobe,
    output logic            done
);
    logic            accept;
    logic [TB_W-1:0] sel_byte;

    assign accept   = req_valid && req_ready;
    assign sel_byte = req_cmd ? ctrl_timing : data_timing;

    pio_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_byte  (sel_byte),
        .start_write (req_write),
        .iordy_en    (iordy_en),
        .iordy       (iordy),
        .ready       (req_ready),
        .addr_valid  (addr_valid),
        .rd_strobe   (rd_strobe),
        .wr_strobe   (wr_strobe),
        .done        (done)
    );

    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe));

    // R8
    busy_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe || wr_strobe || addr_valid || done) |-> !req_ready);

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!req_ready && addr_valid && !rd_strobe && !wr_strobe));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R2
    setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_strobe || wr_strobe) |-> $past(addr_valid));

    // R4
    hold_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_strobe || wr_strobe) |-> (addr_valid && !done));
endmodule

// File: tb/pio_strobe_gen_test.sv
module pio_strobe_gen_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_cmd = 1'b0, req_write = 1'b0;
    logic       req_ready;
    logic [7:0] data_timing = 8'hF5, ctrl_timing = 8'hDE;
    logic       iordy_en = 1'b0, iordy = 1'b1;
    logic       addr_valid, rd_strobe, wr_strobe, done;

    int total = 0;
    int bad   = 0;
    string scen = "R1";

    always #(CLK_P/2) clk = ~clk;

    pio_strobe_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_write(req_write), .req_ready(req_ready), .data_timing(data_timing),
        .ctrl_timing(ctrl_timing), .iordy_en(iordy_en), .iordy(iordy),
        .addr_valid(addr_valid), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .done(done)
    );

    function automatic int setup_len(logic [7:0] b);
        return int'(b[7:6]) + 1;
    endfunction
    function automatic int hold_len(logic [7:0] b);
        int t[8] = '{1, 2, 3, 4, 5, 6, 8, 12};
        return t[b[5:3]];
    endfunction
    function automatic int active_len(logic [7:0] b);
        int t[8] = '{2, 3, 4, 5, 6, 8, 12, 16};
        return t[b[2:0]];
    endfunction

    task automatic chk(string tag, string sig, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s [%s] %s act=%0b exp=%0b t=%0t", tag, scen, sig, act, exp, $time);
        end
    endtask

    // reference model: per-clock queue of phase codes 1=setup 2=active 3=hold 4=done
    int         q[$];
    int         code = 0;
    bit         exp_w = 0;
    logic [7:0] b;
    string      tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            code = 0;
            q.delete();
        end else if (code == 0) begin
            if (req_valid) begin
                b = req_cmd ? ctrl_timing : data_timing;
                exp_w = req_write;
                for (int i = 0; i < setup_len(b); i++)  q.push_back(1);
                for (int i = 0; i < active_len(b); i++) q.push_back(2);
                for (int i = 0; i < hold_len(b); i++)   q.push_back(3);
                q.push_back(4);
                code = q.pop_front();
            end
        end else if (code == 2 && (q.size() == 0 || q[0] != 2) && iordy_en && !iordy) begin
            code = 2;
        end else begin
            code = (q.size() > 0) ? q.pop_front() : 0;
        end
        #(CLK_P/4);
        if (rst_n) begin
            tag = (code == 1) ? "R2" : (code == 2) ? "R3" : (code == 3) ? "R4" :
                  (code == 4) ? "R7" : "R8";
            chk(tag, "req_ready",  req_ready,  code == 0);
            chk(tag, "addr_valid", addr_valid, code >= 1 && code <= 3);
            chk(tag, "rd_strobe",  rd_strobe,  code == 2 && !exp_w);
            chk(tag, "wr_strobe",  wr_strobe,  code == 2 &&  exp_w);
            chk(tag, "done",       done,       code == 4);
        end
    end

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic run_one(logic cmd, logic wr);
        @(negedge clk);
        req_cmd = cmd; req_write = wr; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "req_ready",  req_ready,  1'b1);
        chk("R1", "addr_valid", addr_valid, 1'b0);
        chk("R1", "rd_strobe",  rd_strobe,  1'b0);
        chk("R1", "wr_strobe",  wr_strobe,  1'b0);
        chk("R1", "done",       done,       1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 port select, R6 direction
        scen = "R5_R6";
        for (int c = 0; c < 2; c++)
            for (int w = 0; w < 2; w++)
                run_one(c[0], w[0]);

        // R2 R3 R4 code sweep on both timing bytes
        scen = "R2_R3_R4";
        data_timing = 8'h00; run_one(1'b0, 1'b0);
        data_timing = 8'hFF; run_one(1'b0, 1'b1);
        data_timing = 8'h09; run_one(1'b0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            data_timing = {k[1:0], k[2:0], k[2:0]};
            ctrl_timing = {~k[1:0], ~k[2:0], k[2:0]};
            run_one(1'b0, k[0]);
            run_one(1'b1, ~k[0]);
        end
        data_timing = 8'hF5; ctrl_timing = 8'hDE;

        // R8 requests held while busy
        scen = "R8";
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 1'b0; req_write = 1'b0;
        repeat (5) @(negedge clk);
        req_write = 1'b1; req_cmd = 1'b1;
        repeat (40) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();

        // R9 IORDY stretch at the last active clock
        scen = "R9";
        iordy_en = 1'b1;
        data_timing = 8'h00;
        for (int d = 2; d < 9; d++) begin
            @(negedge clk);
            req_cmd = 1'b0; req_write = d[0]; req_valid = 1'b1; iordy = 1'b0;
            while (!req_ready) @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            repeat (d) @(negedge clk);
            iordy = 1'b1;
            wait_idle();
        end
        // R9 low pulse inside a long active phase: no stretch
        data_timing = 8'h07;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        iordy = 1'b0;
        repeat (6) @(negedge clk);
        iordy = 1'b1;
        wait_idle();
        // R9 IORDY ignored when disabled
        iordy_en = 1'b0; iordy = 1'b0;
        data_timing = 8'h00;
        run_one(1'b0, 1'b1);
        run_one(1'b1, 1'b0);
        iordy = 1'b1;

        // R10 byte rewritten mid-cycle
        scen = "R10";
        data_timing = 8'h00;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 1'b0; req_write = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        data_timing = 8'hFF; ctrl_timing = 8'hFF;
        wait_idle();
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 1'b1; req_write = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        data_timing = 8'h00; ctrl_timing = 8'h00;
        wait_idle();

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog [%s] act=hung exp=finished", scen);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule